// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block produces the serial clock for an I2C master from the system clock. Software loads a 12-bit divider and a speed-mode bit through two 8-bit register writes. While the block is enabled and the divider is valid, it alternates between a driven-low phase and a released-high phase. The phase lengths follow from the divider and the mode. The SCL output is open-drain: `scl_oe` high means the line is pulled low.

The block has three single-cycle strobes for the byte engine around it. The first marks the start of each low phase, where the engine changes SDA. The second marks the start of each high phase. The third marks the first cycle of a high phase in which the line is actually seen high, which is where SDA is sampled.

If a target device holds SCL low while the block has released it, the high-phase count waits. This implements clock stretching. A third register holds a 3-bit input-clock range code for use elsewhere in the controller.

Top module: `scl_div_gen`

## Requirements
- R1: While reset is asserted and after its release, `scl_oe` and all three strobes are 0. The divider reads 0, standard mode is selected, and the range code reads 2.
- R2: A write to address 0 sets fast mode from data bit 7 (1 = fast) and sets divider bits 6:0 from data bits 6:0. Divider bits 11:7 are left unchanged.
- R3: A write to address 1 sets divider bits 11:7 from data bits 4:0. Data bits 7:5 are ignored, and divider bits 6:0 and the mode are left unchanged.
- R4: A write to address 2 sets the range code from data bits 7:5. A write to address 3 changes nothing.
- R5: When the divider is below 2, no low phase is started and SCL stays released, even while `enable` is high.
- R6: In standard mode with divider N, each low phase lasts N+3 cycles and each unstretched high phase lasts N+2 cycles. The period is therefore 2N+5 cycles.
- R7: In fast mode with divider N, each low phase lasts 2N+4 cycles and each unstretched high phase lasts N+2 cycles. The period is therefore 3N+6 cycles.
- R8: During a high phase, each cycle in which `scl_in` is low does not count toward the phase length. This holds the line released for longer (clock stretching).
- R9: Divider and mode are captured only when a low phase starts. A write during a period takes effect from the next low phase.
- R10: `fall_tick` is high in the first cycle of each low phase. `rise_tick` is high in the first cycle of each high phase. `sample_tick` is high in the first cycle of a high phase in which `scl_in` is high.
- R11: When `enable` falls, the period in progress completes and SCL is then left released with no further low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run SCL generation |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 divider extension, 2 range, 3 unused |
| wr_data | input | 8 | Register write data |
| scl_in | input | 1 | Observed SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| fall_tick | output | 1 | First cycle of a low phase |
| rise_tick | output | 1 | First cycle of a high phase |
| sample_tick | output | 1 | First cycle SCL is seen high in a high phase |
| div_value | output | 12 | Current divider register value |
| fast_mode | output | 1 | Current mode bit |
| clk_range | output | 3 | Input-clock range code |

## Verification
The hardest case to reach is a divider rewrite that lands inside a running period. The bench must then see the old lengths for the remainder of that period and the new lengths only from the next falling edge. The stimulus waits for a fall strobe and writes a new divider one cycle into the low phase. It then measures the low and high lengths of the current period and of the following one. Clock stretching is reached by pulling the modelled wired-AND line low just after a rise strobe for a fixed number of cycles. A per-cycle behavioural model tracks all outputs throughout.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_EXT   = 2'd1;
  localparam logic [1:0] ADDR_RANGE = 2'd2;

  // divider bits held in the control register
  localparam int CTRL_DIV_BITS = 7;
  localparam int MODE_BIT      = 7;
endpackage

// File: rtl/scl_div_rst_sync.sv
module scl_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/scl_div_regs.sv
module scl_div_regs
  import scl_div_pkg::*;
#(
  parameter int         DIV_W     = 12,
  parameter logic [2:0] RANGE_RST = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [DIV_W-1:0] div_value,
  output logic             fast_mode,
  output logic [2:0]       clk_range
);
  localparam int HI_W = DIV_W - CTRL_DIV_BITS;

  logic [CTRL_DIV_BITS-1:0] lo_q, lo_d;
  logic [HI_W-1:0]          hi_q, hi_d;
  logic                     fast_q, fast_d;
  logic [2:0]               range_q, range_d;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    fast_d  = fast_q;
    range_d = range_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          lo_d   = wr_data[CTRL_DIV_BITS-1:0];
          fast_d = wr_data[MODE_BIT];
        end
        ADDR_EXT:   hi_d    = wr_data[HI_W-1:0];
        ADDR_RANGE: range_d = wr_data[7:5];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      fast_q  <= 1'b0;
      range_q <= RANGE_RST;
    end else begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      fast_q  <= fast_d;
      range_q <= range_d;
    end
  end

  assign div_value = {hi_q, lo_q};
  assign fast_mode = fast_q;
  assign clk_range = range_q;
endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
  import scl_div_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_value,
  input  logic             fast_mode,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             fall_tick,
  output logic             rise_tick,
  output logic             sample_tick,
  output logic             in_high
);
  localparam int CNT_W = DIV_W + 2;

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DIV_W-1:0]  n_q, n_d;
  logic              fresh_q, fresh_d;
  logic              seen_q, seen_d;
  logic              div_ok;
  logic [CNT_W-1:0]  lo_load;
  logic [CNT_W-1:0]  hi_load;

  assign div_ok = enable && (div_value >= DIV_W'(2));

  // low length minus one, from the live register value
  always_comb begin
    if (fast_mode) lo_load = ({2'b00, div_value} << 1) + CNT_W'(3);
    else           lo_load = {2'b00, div_value} + CNT_W'(2);
  end
  // high length minus one, from the captured divider
  assign hi_load = {2'b00, n_q} + CNT_W'(1);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    n_d     = n_q;
    fresh_d = 1'b0;
    seen_d  = seen_q;
    case (ph_q)
      PH_IDLE: begin
        if (div_ok) begin
          ph_d    = PH_LOW;
          cnt_d   = lo_load;
          n_d     = div_value;
          fresh_d = 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          ph_d    = PH_HIGH;
          cnt_d   = hi_load;
          fresh_d = 1'b1;
          seen_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HIGH: begin
        if (scl_in) begin
          seen_d = 1'b1;
          if (cnt_q == '0) begin
            if (div_ok) begin
              ph_d    = PH_LOW;
              cnt_d   = lo_load;
              n_d     = div_value;
              fresh_d = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      n_q     <= '0;
      fresh_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      n_q     <= n_d;
      fresh_q <= fresh_d;
      seen_q  <= seen_d;
    end
  end

  assign scl_oe      = (ph_q == PH_LOW);
  assign in_high     = (ph_q == PH_HIGH);
  assign fall_tick   = scl_oe && fresh_q;
  assign rise_tick   = in_high && fresh_q;
  assign sample_tick = in_high && scl_in && !seen_q;
endmodule

// File: rtl/scl_div_gen.sv
module scl_div_gen #(
  parameter int         DIV_W       = 12,
  parameter logic [2:0] RANGE_RST   = 3'd2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             fall_tick,
  output logic             rise_tick,
  output logic             sample_tick,
  output logic [DIV_W-1:0] div_value,
  output logic             fast_mode,
  output logic [2:0]       clk_range
);
  logic rst_n_int;
  logic in_high;

  scl_div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  scl_div_regs #(.DIV_W(DIV_W), .RANGE_RST(RANGE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_value(div_value), .fast_mode(fast_mode),
    .clk_range(clk_range)
  );

  scl_div_phase #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst_n(rst_n_int), .enable(enable), .div_value(div_value),
    .fast_mode(fast_mode), .scl_in(scl_in), .scl_oe(scl_oe),
    .fall_tick(fall_tick), .rise_tick(rise_tick),
    .sample_tick(sample_tick), .in_high(in_high)
  );
endmodule

// File: rtl/scl_div_gen_chk.sv
module scl_div_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_oe,
  input logic             scl_in,
  input logic             fall_tick,
  input logic             rise_tick,
  input logic             sample_tick,
  input logic             in_high,
  input logic [DIV_W-1:0] div_value
);
  // R5
  div_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> ($past(div_value) >= DIV_W'(2)));

  // R10
  fall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> fall_tick);

  // R10
  rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (!scl_oe && $past(scl_oe)));

  // R10
  sample_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (!scl_oe && scl_in));

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_in) |=> (in_high && !scl_oe));

  // R10
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_tick, rise_tick}));
endmodule

bind scl_div_gen scl_div_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .scl_in(scl_in),
  .fall_tick(fall_tick), .rise_tick(rise_tick), .sample_tick(sample_tick),
  .in_high(in_high), .div_value(div_value)
);

// File: tb/scl_div_gen_bench.sv
module scl_div_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic stretch = 1'b0;
  logic scl_in, scl_oe, fall_tick, rise_tick, sample_tick, fast_mode;
  logic [11:0] div_value;
  logic [2:0] clk_range;

  assign scl_in = ~scl_oe & ~stretch;

  scl_div_gen u_scl_div_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .scl_in(scl_in),
    .scl_oe(scl_oe), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .sample_tick(sample_tick), .div_value(div_value),
    .fast_mode(fast_mode), .clk_range(clk_range)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_div = 0, m_fast = 0, m_range = 2, m_ph = 0, m_left = 0, m_n = 0;
  bit m_first = 0, m_seen = 0, nxt_first, go;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_fast = 0; m_range = 2; m_ph = 0; m_left = 0; m_n = 0;
      m_first = 0; m_seen = 0;
    end else begin
      nxt_first = 0;
      go = 0;
      if (m_ph == 0) begin
        go = enable && (m_div >= 2);
      end else if (m_ph == 1) begin
        if (m_left == 1) begin
          m_ph = 2; m_left = m_n + 2; m_seen = 0; nxt_first = 1;
        end else m_left--;
      end else if (scl_in) begin
        m_seen = 1;
        if (m_left == 1) begin
          if (enable && (m_div >= 2)) go = 1; else m_ph = 0;
        end else m_left--;
      end
      if (go) begin
        m_ph = 1; m_n = m_div; nxt_first = 1;
        m_left = m_fast ? (2 * m_div + 4) : (m_div + 3);
      end
      m_first = nxt_first;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_div = (m_div & 32'hF80) | wr_data[6:0]; m_fast = wr_data[7]; end
          2'd1: m_div = (m_div & 32'h07F) | (int'(wr_data[4:0]) << 7);
          2'd2: m_range = wr_data[7:5];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and phase measurement
  int lo_cnt = 0, hi_cnt = 0, last_lo = 0, last_hi = 0;
  bit hi_act = 0;

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(scl_oe == (m_ph == 1), "R6 R7 scl_oe", scl_oe, m_ph == 1);
      check(fall_tick == (m_ph == 1 && m_first), "R10 fall_tick", fall_tick, m_ph == 1 && m_first);
      check(rise_tick == (m_ph == 2 && m_first), "R10 rise_tick", rise_tick, m_ph == 2 && m_first);
      check(sample_tick == (m_ph == 2 && scl_in && !m_seen), "R10 sample_tick",
            sample_tick, m_ph == 2 && scl_in && !m_seen);
      check(div_value == m_div, "R2 R3 div_value", div_value, m_div);
      check(clk_range == m_range, "R4 clk_range", clk_range, m_range);
    end
    if (rise_tick) begin
      last_lo = lo_cnt; lo_cnt = 0; hi_cnt = 1; hi_act = 1;
    end else if (fall_tick) begin
      if (hi_act) last_hi = hi_cnt;
      hi_act = 0; lo_cnt = 1;
    end else if (scl_oe) lo_cnt++;
    else if (hi_act) hi_cnt++;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!fall_tick);
    #1;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_tick);
    #1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int falls, rises, oe_seen;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(scl_oe == 0 && fall_tick == 0 && rise_tick == 0 && sample_tick == 0,
          "R1 outputs in reset", scl_oe, 0);
    check(div_value == 0 && fast_mode == 0, "R1 divider reset", div_value, 0);
    check(clk_range == 3'd2, "R1 range reset", clk_range, 2);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_oe == 0 && clk_range == 3'd2, "R1 after release", scl_oe, 0);
    #1 cmp_on = 1;

    // R2
    wr(2'd0, 8'h05);
    check(div_value == 12'd5 && fast_mode == 0, "R2 ctrl write", div_value, 5);
    wr(2'd0, 8'h83);
    check(fast_mode == 1 && div_value == 12'd3, "R2 fast bit", fast_mode, 1);
    wr(2'd0, 8'h05);
    // R3
    wr(2'd1, 8'hE1);
    check(div_value == 12'h085, "R3 ext write", div_value, 12'h085);
    check(fast_mode == 0, "R3 mode untouched", fast_mode, 0);
    wr(2'd1, 8'h00);
    check(div_value == 12'd5, "R3 ext clear", div_value, 5);
    // R4
    wr(2'd2, 8'hBF);
    check(clk_range == 3'd5, "R4 range write", clk_range, 5);
    wr(2'd3, 8'hFF);
    check(div_value == 12'd5 && fast_mode == 0 && clk_range == 3'd5,
          "R4 address 3 ignored", div_value, 5);

    // R5
    wr(2'd0, 8'h01);
    enable = 1'b1;
    oe_seen = 0;
    repeat (40) begin @(negedge clk); if (scl_oe) oe_seen++; end
    check(oe_seen == 0, "R5 divider 1 idle", oe_seen, 0);
    wr(2'd0, 8'h00);
    repeat (10) begin @(negedge clk); if (scl_oe) oe_seen++; end
    check(oe_seen == 0, "R5 divider 0 idle", oe_seen, 0);

    // R6
    wr(2'd0, 8'h05);
    wait_fall(); wait_rise(); wait_rise();
    check(last_lo == 8, "R6 std low", last_lo, 8);
    wait_fall();
    check(last_hi == 7, "R6 std high", last_hi, 7);

    // R9
    wr(2'd0, 8'h07);
    wait_rise();
    check(last_lo == 8, "R9 old low kept", last_lo, 8);
    wait_fall();
    check(last_hi == 7, "R9 old high kept", last_hi, 7);
    wait_rise();
    check(last_lo == 10, "R9 new low", last_lo, 10);
    wait_fall();
    check(last_hi == 9, "R9 new high", last_hi, 9);

    // R7
    wr(2'd0, 8'h83);
    wait_fall(); wait_rise();
    check(last_lo == 10, "R7 fast low", last_lo, 10);
    wait_fall();
    check(last_hi == 5, "R7 fast high", last_hi, 5);

    // R8
    wr(2'd0, 8'h05);
    wait_fall(); wait_rise();
    stretch = 1'b1;
    repeat (4) @(negedge clk);
    #1 stretch = 1'b0;
    wait_fall();
    check(last_hi == 11, "R8 stretched high", last_hi, 11);
    wait_rise(); wait_fall();
    check(last_hi == 7, "R8 next high normal", last_hi, 7);

    // R11
    wait_fall();
    enable = 1'b0;
    falls = 0; rises = 0;
    repeat (60) begin
      @(negedge clk);
      if (fall_tick) falls++;
      if (rise_tick) rises++;
    end
    check(falls == 0, "R11 no new low", falls, 0);
    check(rises == 1, "R11 period completes", rises, 1);
    check(scl_oe == 0, "R11 released", scl_oe, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule